// File: doc/BRIEF.md
# Frequency and Period Measurement Counter

This block measures an external signal in one of three ways and holds the result in a counter of `CNT_W` bits (20 by default). In the two frequency modes it counts rising edges during a fixed gate window. The high-range input is first halved by a divide-by-two. The low-range input is counted as it arrives. In period mode it counts ticks of an internal reference, derived from the system clock, across one or two full periods of the low-range input. This is reciprocal measurement, suited to slow signals.

A controller chooses the mode and the gate code, then raises `cfg_enable` to start a measurement. Dropping `cfg_enable` clears the counter and its flags. While the block stays enabled, a `start_pulse` begins a new measurement whose count adds to the value already held, so readings integrate over several runs. When a run ends, `done` rises. The held value can then be copied into a shift register and read out one bit at a time, most significant bit first. Both inputs pass through a two-flop synchroniser, and only rising edges are counted.

Top module: `freq_period_counter`

## Requirements
- R1: While `cfg_enable` is 0, one clock edge clears `count`, `done` and `overflow` to 0, and `start_pulse` has no effect.
- R2: With `cfg_hi_sel`=0 and `cfg_lo_freq`=1, a run adds one to `count` for each rising edge of `lo_in` that falls inside the gate window.
- R3: With `cfg_hi_sel`=1 the high-range input is measured whatever `cfg_lo_freq` is, and a run adds floor(N/2) for N rising edges of `hi_in` in the gate window. The divide-by-two starts from zero at every start.
- R4: In frequency mode, gate codes 00, 01, 10 and 11 give a window of 4, 8, 32 and 64 times `MS_TICKS` reference ticks. One reference tick is `REF_DIV` clock cycles.
- R5: With `cfg_hi_sel`=0 and `cfg_lo_freq`=0, the run waits for a rising edge of `lo_in`. It then adds one reference tick per `REF_DIV` cycles until one more rising edge (gate bit 0 = 0) or two more rising edges (gate bit 0 = 1) arrive. Gate bit 1 is ignored in this mode.
- R6: `done` rises when a run ends. It stays high until `cfg_enable` falls or a new start arrives, and a start clears it on the next edge.
- R7: A `start_pulse` while `cfg_enable` stays 1 starts a new run without clearing `count`, so successive results add up.
- R8: When `count` passes its maximum it wraps modulo 2^`CNT_W`, and `overflow` sets and stays set until `cfg_enable` falls.
- R9: `rd_load` copies `count` into a shift register whose top bit appears on `rd_bit` after that edge. Each `rd_shift` moves the next lower bit onto `rd_bit`.
- R10: Once a run has ended, further input edges leave `count` unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Clears the block when 0; a 0-to-1 change starts a run |
| start_pulse | input | 1 | Starts a new, integrating run while enabled |
| cfg_hi_sel | input | 1 | 1 selects the high-range input in frequency mode |
| cfg_lo_freq | input | 1 | With `cfg_hi_sel`=0: 1 selects low-range frequency mode, 0 selects period mode |
| cfg_gate | input | 2 | Gate-time code, or the period count (bit 0) in period mode |
| hi_in | input | 1 | High-range signal, asynchronous |
| lo_in | input | 1 | Low-range signal, asynchronous |
| rd_load | input | 1 | Copies the count into the readout shift register |
| rd_shift | input | 1 | Shifts the readout register by one bit |
| count | output | CNT_W | Accumulated measurement value |
| done | output | 1 | End-of-count flag |
| overflow | output | 1 | Sticky counter wrap flag |
| rd_bit | output | 1 | Serial readout, MSB first |

## Verification
Counter wrap is the state hardest to reach from the ports, because a full-width count needs an enormous number of edges. The bench therefore builds the block with an 8-bit counter. It then drives a long period-mode measurement, where reference ticks add up quickly, so the result passes 255. The bench predicts the wrapped value exactly: it makes the input period a multiple of the reference divider, which fixes the tick count. Integration and the divide-by-two phase are reached by restarting with `start_pulse` while enabled, with odd edge counts.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } fpc_state_e;

    typedef enum logic [1:0] {
        MODE_HI_FREQ   = 2'd0,
        MODE_LO_FREQ   = 2'd1,
        MODE_LO_PERIOD = 2'd2
    } fpc_mode_e;

endpackage

// File: rtl/fpc_edge_sync.sv
module fpc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_regs_t;

    sync_regs_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[STAGES-2:0], async_in};
        d.last = q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise = q.sync[STAGES-1] & ~q.last;
endmodule

// File: rtl/fpc_tick_gen.sv
module fpc_tick_gen #(
    parameter int REF_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (cnt_q == CW'(REF_DIV - 1)) cnt_d = '0;
        else                           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == CW'(REF_DIV - 1));
endmodule

// File: rtl/fpc_shift_out.sv
module fpc_shift_out #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] value,
    output logic         bit_out
);
    logic [W-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = sh_q;
        if (load)       sh_d = value;
        else if (shift) sh_d = {sh_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign bit_out = sh_q[W-1];

    assert_load_msb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bit_out == $past(value[W-1])));
endmodule

// File: rtl/freq_period_counter.sv
module freq_period_counter
    import fpc_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int REF_DIV  = 8,
    parameter int MS_TICKS = 900,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             start_pulse,
    input  logic             cfg_hi_sel,
    input  logic             cfg_lo_freq,
    input  logic [1:0]       cfg_gate,
    input  logic             hi_in,
    input  logic             lo_in,
    input  logic             rd_load,
    input  logic             rd_shift,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             overflow,
    output logic             rd_bit
);
    localparam int GATE_W = $clog2(MS_TICKS * 64) + 1;
    localparam logic [GATE_W-1:0] GATE_LEN0 = GATE_W'(MS_TICKS * 4);
    localparam logic [GATE_W-1:0] GATE_LEN1 = GATE_W'(MS_TICKS * 8);
    localparam logic [GATE_W-1:0] GATE_LEN2 = GATE_W'(MS_TICKS * 32);
    localparam logic [GATE_W-1:0] GATE_LEN3 = GATE_W'(MS_TICKS * 64);

    typedef struct packed {
        fpc_state_e        st;
        fpc_mode_e         mode;
        logic [1:0]        gate;
        logic              en;
        logic              hdiv;
        logic [GATE_W-1:0] gcnt;
        logic              pcnt;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              ovf;
    } regs_t;

    regs_t q, d;

    logic hi_rise, lo_rise, ref_tick;

    fpc_edge_sync #(.STAGES(SYNC_N)) u_hi_sync (
        .clk(clk), .rst_n(rst_n), .async_in(hi_in), .rise(hi_rise));

    fpc_edge_sync #(.STAGES(SYNC_N)) u_lo_sync (
        .clk(clk), .rst_n(rst_n), .async_in(lo_in), .rise(lo_rise));

    fpc_tick_gen #(.REF_DIV(REF_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick));

    fpc_shift_out #(.W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .shift(rd_shift),
        .value(q.cnt), .bit_out(rd_bit));

    logic [GATE_W-1:0] gate_last;
    logic              start_evt;
    logic              inc;
    logic [CNT_W:0]    sum;

    always_comb begin
        unique case (q.gate)
            2'd0:    gate_last = GATE_LEN0 - 1'b1;
            2'd1:    gate_last = GATE_LEN1 - 1'b1;
            2'd2:    gate_last = GATE_LEN2 - 1'b1;
            default: gate_last = GATE_LEN3 - 1'b1;
        endcase
    end

    assign start_evt = cfg_enable && (!q.en || start_pulse);
    assign sum       = {1'b0, q.cnt} + {{CNT_W{1'b0}}, 1'b1};

    always_comb begin
        d    = q;
        inc  = 1'b0;
        d.en = cfg_enable;
        if (!cfg_enable) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.done = 1'b0;
            d.ovf  = 1'b0;
            d.gcnt = '0;
            d.pcnt = 1'b0;
            d.hdiv = 1'b0;
        end else if (start_evt) begin
            d.done = 1'b0;
            d.hdiv = 1'b0;
            d.gcnt = '0;
            d.pcnt = 1'b0;
            d.gate = cfg_gate;
            if (cfg_hi_sel) begin
                d.mode = MODE_HI_FREQ;
                d.st   = ST_RUN;
            end else if (cfg_lo_freq) begin
                d.mode = MODE_LO_FREQ;
                d.st   = ST_RUN;
            end else begin
                d.mode = MODE_LO_PERIOD;
                d.st   = ST_ARM;
            end
        end else begin
            unique case (q.st)
                ST_ARM: begin
                    if (lo_rise) d.st = ST_RUN;
                end
                ST_RUN: begin
                    if (q.mode == MODE_LO_PERIOD) begin
                        inc = ref_tick;
                        if (lo_rise) begin
                            if (q.pcnt == q.gate[0]) begin
                                d.done = 1'b1;
                                d.st   = ST_IDLE;
                            end else begin
                                d.pcnt = 1'b1;
                            end
                        end
                    end else begin
                        if (q.mode == MODE_HI_FREQ) begin
                            inc = hi_rise & q.hdiv;
                            if (hi_rise) d.hdiv = ~q.hdiv;
                        end else begin
                            inc = lo_rise;
                        end
                        if (ref_tick) begin
                            if (q.gcnt == gate_last) begin
                                d.done = 1'b1;
                                d.st   = ST_IDLE;
                            end else begin
                                d.gcnt = q.gcnt + 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
            if (inc) begin
                d.cnt = sum[CNT_W-1:0];
                if (sum[CNT_W]) d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count    = q.cnt;
    assign done     = q.done;
    assign overflow = q.ovf;

    assert_clear_on_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (count == '0 && !done && !overflow));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && q.st == ST_RUN) |=>
            (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

    assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_enable && q.en && !start_pulse) |=> done);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && cfg_enable) |=> overflow);

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && q.st != ST_RUN) |=> $stable(count));
endmodule

// File: tb/freq_period_counter_tb.sv
module freq_period_counter_tb;
    localparam int CNT_W    = 8;
    localparam int REF_DIV  = 2;
    localparam int MS_TICKS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0, start_pulse = 1'b0, cfg_hi_sel = 1'b0, cfg_lo_freq = 1'b0;
    logic [1:0] cfg_gate = 2'd0;
    logic hi_in = 1'b0, lo_in = 1'b0, rd_load = 1'b0, rd_shift = 1'b0;
    logic [CNT_W-1:0] count;
    logic done, overflow, rd_bit;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    freq_period_counter #(.CNT_W(CNT_W), .REF_DIV(REF_DIV), .MS_TICKS(MS_TICKS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .start_pulse(start_pulse),
        .cfg_hi_sel(cfg_hi_sel), .cfg_lo_freq(cfg_lo_freq), .cfg_gate(cfg_gate),
        .hi_in(hi_in), .lo_in(lo_in), .rd_load(rd_load), .rd_shift(rd_shift),
        .count(count), .done(done), .overflow(overflow), .rd_bit(rd_bit));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic pulses(input logic use_hi, input int n);
        for (int i = 0; i < n; i++) begin
            if (use_hi) hi_in = 1'b1; else lo_in = 1'b1;
            repeat (2) @(negedge clk);
            hi_in = 1'b0; lo_in = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic wait_done(output int elapsed, input int t0);
        int guard = 0;
        while (!done && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        elapsed = cyc - t0;
    endtask

    task automatic disable_all();
        @(negedge clk);
        cfg_enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // R2 / R3 / R4: one frequency run from a cleared state
    task automatic freq_run(input logic hi, input logic lof, input logic [1:0] g, input int n);
        int t0, el, glen, expv;
        disable_all();
        cfg_hi_sel = hi; cfg_lo_freq = lof; cfg_gate = g;
        cfg_enable = 1'b1;
        t0 = cyc;
        @(negedge clk);
        pulses(hi, n);
        wait_done(el, t0);
        case (g)
            2'd0: glen = 4 * MS_TICKS;
            2'd1: glen = 8 * MS_TICKS;
            2'd2: glen = 32 * MS_TICKS;
            default: glen = 64 * MS_TICKS;
        endcase
        expv = hi ? n / 2 : n;
        if (hi) check("R3 high-range halved count", int'(count), expv);
        else    check("R2 low-range edge count", int'(count), expv);
        check_range("R4 gate duration", el, (glen - 1) * REF_DIV + 2, glen * REF_DIV + 1);
        check("R6 done after gate", int'(done), 1);
    endtask

    // R5: period mode, three input periods of p cycles sent
    task automatic per_run(input logic [1:0] g, input int p, output int exp_raw);
        disable_all();
        cfg_hi_sel = 1'b0; cfg_lo_freq = 1'b0; cfg_gate = g;
        cfg_enable = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            lo_in = 1'b1;
            repeat (p / 2) @(negedge clk);
            lo_in = 1'b0;
            repeat (p / 2) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        exp_raw = (g[0] ? 2 : 1) * p / REF_DIV;
    endtask

    task automatic readout(input int expv);
        int got = 0;
        rd_load = 1'b1;
        @(negedge clk);
        rd_load = 1'b0;
        for (int i = 0; i < CNT_W; i++) begin
            got = (got << 1) | int'(rd_bit);
            rd_shift = 1'b1;
            @(negedge clk);
            rd_shift = 1'b0;
        end
        check("R9 serial readout MSB first", got, expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ex, el, t0, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset count", int'(count), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset overflow", int'(overflow), 0);

        // R1: start_pulse and edges while disabled have no effect
        cfg_lo_freq = 1'b1;
        start_pulse = 1'b1;
        pulses(1'b0, 3);
        start_pulse = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 disabled count", int'(count), 0);
        check("R1 disabled done", int'(done), 0);

        // R2 / R3 / R4 sweep over gates and edge counts
        for (int g = 0; g < 4; g++) begin
            foreach (ex_n[i]) begin
                freq_run(1'b0, 1'b1, 2'(g), ex_n[i]);
                freq_run(1'b1, ex_n[i][0], 2'(g), ex_n[i]);
            end
        end

        // R10: edges after the end of a run leave count unchanged
        v = int'(count);
        pulses(1'b1, 6);
        repeat (4) @(negedge clk);
        check("R10 count frozen after done", int'(count), v);

        // R7 / R6: integrating run
        freq_run(1'b0, 1'b1, 2'd0, 5);
        start_pulse = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start_pulse = 1'b0;
        check("R6 done cleared by start", int'(done), 0);
        pulses(1'b0, 7);
        wait_done(el, t0);
        check("R7 integrated sum", int'(count), 12);
        check("R6 done after second run", int'(done), 1);
        // R3: divider restarts at each start (odd counts do not carry over)
        cfg_hi_sel = 1'b1;
        start_pulse = 1'b1;
        @(negedge clk);
        start_pulse = 1'b0;
        pulses(1'b1, 3);
        wait_done(el, cyc);
        check("R3 divide-by-two restart", int'(count), 13);
        cfg_hi_sel = 1'b1;
        start_pulse = 1'b1;
        @(negedge clk);
        start_pulse = 1'b0;
        pulses(1'b1, 3);
        wait_done(el, cyc);
        check("R3 divide-by-two restart again", int'(count), 14);
        readout(14);

        // R5: period mode over periods and codes
        foreach (ex_p[i]) begin
            for (int g = 0; g < 4; g++) begin
                per_run(2'(g), ex_p[i], ex);
                check("R5 period count", int'(count), ex);
                check("R5 period done", int'(done), 1);
            end
        end

        // R8: wrap and sticky overflow
        per_run(2'd0, 600, ex);
        check("R8 wrapped value", int'(count), ex % (1 << CNT_W));
        check("R8 overflow set", int'(overflow), 1);
        readout(ex % (1 << CNT_W));
        repeat (5) @(negedge clk);
        check("R8 overflow sticky", int'(overflow), 1);
        cfg_enable = 1'b0;
        @(negedge clk);
        check("R1 disable clears overflow", int'(overflow), 0);
        check("R1 disable clears count", int'(count), 0);
        check("R1 disable clears done", int'(done), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    int ex_n[4] = '{0, 1, 5, 12};
    int ex_p[3] = '{8, 20, 64};
endmodule